// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running BCD calendar (seconds, minutes, hours, weekday, day of month, month, year) delivered on input buses and raises an alarm when the calendar reaches a programmed instant. Each of the seven alarm fields carries its own compare-enable flag. A disabled field matches any calendar value, so an alarm can be set, for example, for a given date and time on any weekday.

Software writes the alarm fields into a staging set. The comparator does not see them until a separate commit write copies the whole set into the active set at once. This means a half-written alarm is never compared. The comparison is sampled only on the one-second tick. A hit sets a sticky pending bit, which software clears by writing one to it. The interrupt output is a level signal: it is high while the pending bit and the interrupt-enable bit are both set.

Top module: `alm_cmp_top`

## Requirements
- R1: After reset the pending bit and the interrupt output are 0, the interrupt enable is 0, and every active alarm field is disabled with value 0.
- R2: Write addresses select the register: 0 seconds (7 value bits), 1 minutes (7), 2 hours (6), 3 weekday (3), 4 day (6), 5 month (5), 6 year (8), 7 commit, 8 interrupt enable, 9 status. In a field write, data bit 15 is that field's compare enable. Data bits above the field's value width, up to bit 14, are discarded.
- R3: A field whose enable is 0 takes no part in the comparison. With the weekday disabled and every other field enabled, a weekday mismatch does not block the alarm.
- R4: Field writes go to the staging set only. The active set takes the staged values when address 7 is written with data bit 15 set. A write to address 7 with bit 15 clear leaves the active set unchanged.
- R5: When tick_i is high in a cycle where every enabled active field equals the calendar, the pending bit is 1 from the next cycle on. Without tick_i, a matching calendar does not set it.
- R6: Writing address 9 with data bit 0 set clears the pending bit. Writing it with bit 0 clear has no effect. If a set and a clear fall in the same cycle, the bit ends up set.
- R7: irq_o is high exactly while the pending bit is 1 and bit 0 of the interrupt-enable register (address 8) is 1. It stays high with no further ticks until the bit is cleared or the enable is removed.
- R8: If no active field is enabled, a tick never sets the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| tick_i | input | 1 | One-cycle pulse once per second |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 6 | Calendar hours, BCD |
| cal_wday_i | input | 3 | Calendar weekday |
| cal_day_i | input | 6 | Calendar day of month, BCD |
| cal_mon_i | input | 5 | Calendar month, BCD |
| cal_year_i | input | 8 | Calendar year, BCD |
| pending_o | output | 1 | Alarm pending status bit |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a match-driven set and a write-one clear landing in the same clock. The bench reaches it by driving a status write and the tick pulse on the same falling edge. A second hard case is telling the staged values apart from the active ones. For this the bench rewrites a field without committing, then issues a commit with the trigger bit clear, and fires ticks against both the old and the new value to show which set the comparator is using.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NFIELD = 7;
  localparam int SLOT_W = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int EN_BIT = 15;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = ADDR_W'(NFIELD);
  localparam logic [ADDR_W-1:0] ADDR_IE     = ADDR_W'(NFIELD + 1);
  localparam logic [ADDR_W-1:0] ADDR_STAT   = ADDR_W'(NFIELD + 2);

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] val;
  } alm_field_t;

  typedef logic [NFIELD-1:0][SLOT_W-1:0] cal_vec_t;

  // value width of each calendar field, indexed by write address
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] field_mask(input int idx);
    logic [SLOT_W-1:0] m;
    m = '0;
    for (int b = 0; b < SLOT_W; b++) m[b] = (b < field_width(idx));
    return m;
  endfunction
endpackage

// File: rtl/alm_stage_regs.sv
module alm_stage_regs
  import alm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic                     wr_flag_i,
  input  logic [SLOT_W-1:0]        wr_val_i,
  output alm_field_t [NFIELD-1:0]  active_o,
  output logic                     commit_evt_o
);
  alm_field_t [NFIELD-1:0] staged_q;
  alm_field_t [NFIELD-1:0] active_q;

  assign commit_evt_o = wr_en_i && (wr_addr_i == ADDR_COMMIT) && wr_flag_i;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    logic fld_wr;
    assign fld_wr = wr_en_i && (wr_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        staged_q[i] <= '0;
      end else if (fld_wr) begin
        staged_q[i].en  <= wr_flag_i;
        staged_q[i].val <= wr_val_i & field_mask(i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)           active_q <= '0;
    else if (commit_evt_o) active_q <= staged_q;
  end

  assign active_o = active_q;

  AST_ACTIVE_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $past(commit_evt_o)) else $error("active set changed without commit"); // R4
endmodule

// File: rtl/alm_field_match.sv
module alm_field_match
  import alm_pkg::*;
(
  input  alm_field_t [NFIELD-1:0] active_i,
  input  cal_vec_t                cal_i,
  output logic [NFIELD-1:0]       en_vec_o,
  output logic [NFIELD-1:0]       eq_vec_o,
  output logic                    any_en_o,
  output logic                    hit_o
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign en_vec_o[i] = active_i[i].en;
    assign eq_vec_o[i] = (active_i[i].val == (cal_i[i] & field_mask(i)));
  end

  assign any_en_o = |en_vec_o;
  assign hit_o    = any_en_o && (&(eq_vec_o | ~en_vec_o));
endmodule

// File: rtl/alm_status.sv
module alm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic any_en_i,
  input  logic ie_wr_i,
  input  logic stat_wr_i,
  input  logic wr_bit0_i,
  output logic pending_o,
  output logic irq_o
);
  logic pend_q, ie_q;
  logic set_evt, clr_evt;

  assign set_evt = tick_i && hit_i;
  assign clr_evt = stat_wr_i && wr_bit0_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (set_evt)      pend_q <= 1'b1;
      else if (clr_evt) pend_q <= 1'b0;
      if (ie_wr_i)      ie_q   <= wr_bit0_i;
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = pend_q && ie_q;

  AST_RISE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(tick_i)) else $error("pending rose without tick"); // R5
  AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> ($past(clr_evt) && !$past(set_evt))) else $error("pending fell without clear"); // R6
  AST_NO_EMPTY_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !any_en_i && !pend_q) |=> !pend_q) else $error("fired with no field enabled"); // R8
  AST_IRQ_FOLLOWS_IE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_wr_i && !wr_bit0_i) |=> !irq_o) else $error("irq high after enable removed"); // R7
endmodule

// File: rtl/alm_cmp_top.sv
module alm_cmp_top
  import alm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic [6:0]        cal_sec_i,
  input  logic [6:0]        cal_min_i,
  input  logic [5:0]        cal_hour_i,
  input  logic [2:0]        cal_wday_i,
  input  logic [5:0]        cal_day_i,
  input  logic [4:0]        cal_mon_i,
  input  logic [7:0]        cal_year_i,
  output logic              pending_o,
  output logic              irq_o
);
  cal_vec_t                cal_vec;
  alm_field_t [NFIELD-1:0] active;
  logic [NFIELD-1:0]       en_vec, eq_vec;
  logic                    any_en, hit, commit_evt;
  logic                    ie_wr, stat_wr;
  logic                    unused_bits;

  // slot index equals the field's write address (R2)
  assign cal_vec[0] = SLOT_W'(cal_sec_i);
  assign cal_vec[1] = SLOT_W'(cal_min_i);
  assign cal_vec[2] = SLOT_W'(cal_hour_i);
  assign cal_vec[3] = SLOT_W'(cal_wday_i);
  assign cal_vec[4] = SLOT_W'(cal_day_i);
  assign cal_vec[5] = SLOT_W'(cal_mon_i);
  assign cal_vec[6] = SLOT_W'(cal_year_i);

  assign unused_bits = ^wr_data_i[EN_BIT-1:SLOT_W];
  assign ie_wr   = wr_en_i && (wr_addr_i == ADDR_IE);
  assign stat_wr = wr_en_i && (wr_addr_i == ADDR_STAT);

  alm_stage_regs i_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_flag_i    (wr_data_i[EN_BIT]),
    .wr_val_i     (wr_data_i[SLOT_W-1:0]),
    .active_o     (active),
    .commit_evt_o (commit_evt)
  );

  alm_field_match i_match (
    .active_i (active),
    .cal_i    (cal_vec),
    .en_vec_o (en_vec),
    .eq_vec_o (eq_vec),
    .any_en_o (any_en),
    .hit_o    (hit)
  );

  alm_status i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .hit_i     (hit),
    .any_en_i  (any_en),
    .ie_wr_i   (ie_wr),
    .stat_wr_i (stat_wr),
    .wr_bit0_i (wr_data_i[0]),
    .pending_o (pending_o),
    .irq_o     (irq_o)
  );

  AST_HIT_NEEDS_ENABLED_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> ((en_vec & ~eq_vec) == '0)) else $error("hit with an enabled field unequal"); // R3
  AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i < ADDR_COMMIT) |=> $stable(en_vec)) else $error("field write reached active set"); // R4
endmodule

// File: tb/test_alm_cmp_top.sv
module test_alm_cmp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [6:0]  c_sec = '0, c_min = '0;
  logic [5:0]  c_hour = '0, c_day = '0;
  logic [2:0]  c_wday = '0;
  logic [4:0]  c_mon = '0;
  logic [7:0]  c_year = '0;
  logic        pending, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [15:0] EN = 16'h8000;

  always #2 clk = ~clk;

  alm_cmp_top i_alm_cmp_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tick_i(tick), .cal_sec_i(c_sec), .cal_min_i(c_min), .cal_hour_i(c_hour), .cal_wday_i(c_wday),
    .cal_day_i(c_day), .cal_mon_i(c_mon), .cal_year_i(c_year), .pending_o(pending), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [2:0] w, input logic [5:0] d, input logic [4:0] mo,
                         input logic [7:0] y);
    c_sec = s; c_min = m; c_hour = h; c_wday = w; c_day = d; c_mon = mo; c_year = y;
  endtask

  task automatic clear_pending();
    wr(4'd9, 16'h0001);
  endtask

  // alarm 12:30:45, day 15, month 06, year 24, weekday disabled
  task automatic program_std();
    wr(4'd0, EN | 16'h45); wr(4'd1, EN | 16'h30); wr(4'd2, EN | 16'h12);
    wr(4'd3, 16'h0005);    wr(4'd4, EN | 16'h15); wr(4'd5, EN | 16'h06);
    wr(4'd6, EN | 16'h24); wr(4'd7, EN);
  endtask

  task automatic t_reset();
    chk("R1 pending after reset", pending, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    set_cal('0, '0, '0, '0, '0, '0, '0);
    pulse_tick();
    chk("R1 all fields disabled after reset", pending, 1'b0);
  endtask

  task automatic t_main_match();
    program_std();
    wr(4'd8, 16'h0001);
    set_cal(7'h44, 7'h30, 6'h12, 3'd2, 6'h15, 5'h06, 8'h24);
    pulse_tick();
    chk("R5 seconds differ no fire", pending, 1'b0);
    c_sec = 7'h45;
    pulse_tick();
    chk("R3 weekday disabled match fires", pending, 1'b1);
    chk("R7 irq with enable", irq, 1'b1);
    idle(5);
    chk("R7 irq level holds", irq, 1'b1);
    clear_pending();
    chk("R6 w1c clears pending", pending, 1'b0);
    chk("R7 irq drops on clear", irq, 1'b0);
  endtask

  task automatic t_no_tick();
    idle(6);
    chk("R5 match without tick no set", pending, 1'b0);
  endtask

  task automatic t_staging();
    wr(4'd0, EN | 16'h50);
    pulse_tick();
    chk("R4 staged write not yet active", pending, 1'b1);
    clear_pending();
    wr(4'd7, 16'h0000);
    pulse_tick();
    chk("R4 commit without bit15 ignored", pending, 1'b1);
    clear_pending();
    wr(4'd7, EN);
    pulse_tick();
    chk("R4 committed value replaces old", pending, 1'b0);
    c_sec = 7'h50;
    pulse_tick();
    chk("R4 new value fires", pending, 1'b1);
    clear_pending();
  endtask

  task automatic t_width();
    wr(4'd2, EN | 16'h0FD2);
    wr(4'd7, EN);
    c_hour = 6'h12;
    pulse_tick();
    chk("R2 high data bits discarded", pending, 1'b1);
    clear_pending();
  endtask

  task automatic t_ie_and_w1c();
    wr(4'd8, 16'h0000);
    pulse_tick();
    chk("R5 fires with irq disabled", pending, 1'b1);
    chk("R7 irq gated by enable", irq, 1'b0);
    wr(4'd8, 16'h0001);
    chk("R7 irq on enable without tick", irq, 1'b1);
    wr(4'd9, 16'h0000);
    chk("R6 write zero keeps pending", pending, 1'b1);
    wr(4'd8, 16'h0000);
    chk("R7 irq off when enable removed", irq, 1'b0);
    clear_pending();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h0001; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R6 set wins over same-cycle clear", pending, 1'b1);
    clear_pending();
    chk("R6 clear after set-wins", pending, 1'b0);
  endtask

  task automatic t_empty();
    for (int a = 0; a < 7; a++) wr(a[3:0], 16'h0000);
    wr(4'd7, EN);
    set_cal('0, '0, '0, '0, '0, '0, '0);
    pulse_tick();
    pulse_tick();
    chk("R8 no enabled field never fires", pending, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_match();
    t_no_tick();
    t_staging();
    t_width();
    t_ie_and_w1c();
    t_empty();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule